// File: doc/BRIEF.md
# Packet Timestamp Insertion Unit

This block sits on the egress side of a packet generator and writes the current value of a free-running timestamp counter into Ethernet frames that pass through it on an 8-byte-wide streaming interface with valid/ready handshaking. The counter itself is generated elsewhere. The block only samples the counter and overwrites selected bytes of the frame. It does not rebuild checksums and does not store whole frames. The frame length and every byte that is not stamped leave the block unchanged.

A two-bit mode input selects among three placements. Header mode stamps IPv4 frames only: a 24-bit value overwrites the Identification field and the byte after it. Fixed-position mode stamps a 16-bit or 24-bit value at a byte offset chosen by software. Off mode passes frames through untouched. Mode, offset, width and the counter value are all sampled on the first beat of a frame and held until its last beat. Every byte of a stamp therefore comes from one counter value, and a configuration change lands on a frame boundary.

The data path has a single register stage. The downstream ready signal is fed straight back upstream. An asynchronous active-low reset, released synchronously inside the block, and a synchronous software reset both return the block to the idle, between-frames state.

Top module: `tstamp_inserter`

## Requirements
- R1: While the reset is asserted, and after it is released, `m_tvalid` is 0 until a beat is accepted.
- R2: `s_tready` equals `m_tready` in every cycle.
- R3: A beat is accepted when `s_tvalid` and `m_tready` are both 1. It appears on `m_tdata`, `m_tkeep` and `m_tlast` one cycle later with `m_tvalid`=1. While `m_tready` is 0, the outputs hold their values.
- R4: Mode 0 (`mode_i`=2'b00) and mode 3 (2'b11) forward every frame byte-exact. Frame byte n travels in beat n/8, lane n mod 8, which is `tdata[8*(n%8)+7 : 8*(n%8)]`.
- R5: In mode 1 (header), a frame whose bytes 12 and 13 are 0x08 and 0x00 gets bytes 18, 19 and 20 overwritten with stamp bits [23:16], [15:8] and [7:0].
- R6: In mode 1, a frame with any other value in bytes 12 and 13 is forwarded unchanged.
- R7: In mode 2 (fixed) with `wide_i`=0, bytes pos and pos+1 become stamp bits [15:8] and [7:0]. The offset `pos_i` ranges over 0..1518.
- R8: In mode 2 with `wide_i`=1, bytes pos, pos+1 and pos+2 become stamp bits [23:16], [15:8] and [7:0].
- R9: A stamp byte that would fall in the next beat is dropped. Writing happens only for bytes in the same beat as pos. A position beyond the end of the frame leaves the frame unchanged.
- R10: The stamp value is `tstamp_i` as sampled in the cycle the first beat of the frame is accepted.
- R11: `mode_i`, `pos_i` and `wide_i` are sampled with the first beat. Changes to them during a frame do not affect that frame.
- R12: `sw_rst`=1 at a clock edge clears `m_tvalid` and ends the frame in flight. The next accepted beat is treated as the first beat of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data path clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset, active high |
| mode_i | input | 2 | 0 off, 1 header, 2 fixed position, 3 off |
| pos_i | input | 11 | Byte offset of the stamp in fixed mode |
| wide_i | input | 1 | Fixed mode width: 0 is 16 bits, 1 is 24 bits |
| tstamp_i | input | 24 | Current timestamp counter value |
| s_tdata | input | 64 | Input beat data |
| s_tkeep | input | 8 | Input byte enables |
| s_tvalid | input | 1 | Input beat valid |
| s_tlast | input | 1 | Input last beat of frame |
| s_tready | output | 1 | Input ready, equal to m_tready |
| m_tdata | output | 64 | Output beat data |
| m_tkeep | output | 8 | Output byte enables |
| m_tvalid | output | 1 | Output beat valid |
| m_tlast | output | 1 | Output last beat of frame |
| m_tready | input | 1 | Output ready from downstream |

## Verification
A wrong beat index or a stale frame-start flag moves the stamp into the wrong lane or the wrong beat. This shows up on `m_tdata` one cycle after the affected beat is accepted. A captured configuration or counter value that is refreshed at the wrong time shows up as stamp bytes from two different counter values, or as a stamp that follows a mid-frame mode change, in the very next stamped beat. A lost IPv4 detection shows up only in beat 2 of a header-mode frame. For that reason the stimulus mixes short frames, long frames, stalls and idle gaps, and a reference model compares every output beat in every cycle.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [1:0] {
    TS_OFF  = 2'd0,
    TS_HDR  = 2'd1,
    TS_FIX  = 2'd2,
    TS_OFF3 = 2'd3
  } ts_mode_e;

  // byte offset of the EtherType field inside the frame
  localparam int ETYPE_OFS      = 12;
  // first byte overwritten in header mode
  localparam int HDR_STAMP_OFS  = 18;
  localparam logic [15:0] IPV4_ETYPE = 16'h0800;
endpackage

// File: rtl/tsi_reset_sync.sv
module tsi_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tsi_frame_tracker.sv
module tsi_frame_tracker
  import tsi_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int POS_W      = 11,
  parameter int BEAT_W     = 8,
  parameter int TS_W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              beat_acc,
  input  logic              beat_last,
  input  logic [15:0]       etype_bytes,
  input  ts_mode_e          live_mode,
  input  logic [POS_W-1:0]  live_pos,
  input  logic              live_wide,
  input  logic [TS_W-1:0]   live_ts,
  output logic [BEAT_W-1:0] beat_idx,
  output ts_mode_e          eff_mode,
  output logic [POS_W-1:0]  eff_pos,
  output logic              eff_wide,
  output logic [TS_W-1:0]   eff_ts,
  output logic              is_ipv4
);
  localparam int ETYPE_BEAT = ETYPE_OFS / DATA_BYTES;
  localparam logic [BEAT_W-1:0] BEAT_MAX = '1;

  logic [BEAT_W-1:0] beat_q, beat_d;
  ts_mode_e          mode_q, mode_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic              wide_q, wide_d;
  logic [TS_W-1:0]   ts_q, ts_d;
  logic              ipv4_q, ipv4_d;
  logic              sof;
  logic              upd_en;

  assign sof    = (beat_q == '0);
  assign upd_en = beat_acc | sw_rst;

  // next state
  always_comb begin
    beat_d = beat_q;
    mode_d = mode_q;
    pos_d  = pos_q;
    wide_d = wide_q;
    ts_d   = ts_q;
    ipv4_d = ipv4_q;
    if (sw_rst) begin
      beat_d = '0;
      ipv4_d = 1'b0;
    end else if (beat_acc) begin
      if (beat_last)              beat_d = '0;
      else if (beat_q != BEAT_MAX) beat_d = beat_q + 1'b1;
      if (sof) begin
        mode_d = live_mode;
        pos_d  = live_pos;
        wide_d = live_wide;
        ts_d   = live_ts;
        ipv4_d = 1'b0;
      end
      if (beat_q == BEAT_W'(ETYPE_BEAT))
        ipv4_d = (etype_bytes == IPV4_ETYPE);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      mode_q <= TS_OFF;
      pos_q  <= '0;
      wide_q <= 1'b0;
      ts_q   <= '0;
      ipv4_q <= 1'b0;
    end else if (upd_en) begin
      beat_q <= beat_d;
      mode_q <= mode_d;
      pos_q  <= pos_d;
      wide_q <= wide_d;
      ts_q   <= ts_d;
      ipv4_q <= ipv4_d;
    end
  end

  assign beat_idx = beat_q;
  assign eff_mode = sof ? live_mode : mode_q;
  assign eff_pos  = sof ? live_pos  : pos_q;
  assign eff_wide = sof ? live_wide : wide_q;
  assign eff_ts   = sof ? live_ts   : ts_q;
  assign is_ipv4  = ipv4_q;
endmodule

// File: rtl/tsi_stamp_planner.sv
module tsi_stamp_planner
  import tsi_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int POS_W      = 11,
  parameter int BEAT_W     = 8,
  parameter int TS_W       = 24
) (
  input  logic [BEAT_W-1:0]       beat_idx,
  input  ts_mode_e                mode,
  input  logic [POS_W-1:0]        pos,
  input  logic                    wide,
  input  logic                    is_ipv4,
  input  logic [TS_W-1:0]         ts,
  output logic [DATA_BYTES-1:0]   lane_en,
  output logic [DATA_BYTES*8-1:0] lane_val
);
  localparam int LANE_W = $clog2(DATA_BYTES);
  localparam int CMP_W  = (BEAT_W > POS_W) ? BEAT_W : POS_W;
  localparam logic [POS_W-1:0] HDR_POS = POS_W'(HDR_STAMP_OFS);

  logic             active;
  logic [POS_W-1:0] start;
  logic [1:0]       len;
  logic             hit;
  logic [LANE_W-1:0] start_lane;
  logic [7:0]       sb0, sb1, sb2;

  always_comb begin
    active = 1'b0;
    start  = pos;
    len    = 2'd2;
    case (mode)
      TS_HDR: begin
        active = is_ipv4;
        start  = HDR_POS;
        len    = 2'd3;
      end
      TS_FIX: begin
        active = 1'b1;
        start  = pos;
        len    = wide ? 2'd3 : 2'd2;
      end
      default: ;
    endcase
  end

  assign start_lane = start[LANE_W-1:0];
  assign hit = active && (CMP_W'(beat_idx) == CMP_W'(start >> LANE_W));

  // stamp bytes, most significant first
  assign sb0 = (len == 2'd3) ? ts[TS_W-1 -: 8]  : ts[TS_W-9 -: 8];
  assign sb1 = (len == 2'd3) ? ts[TS_W-9 -: 8]  : ts[TS_W-17 -: 8];
  assign sb2 = ts[TS_W-17 -: 8];

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
    logic [LANE_W:0] rel;
    logic [LANE_W:0] lane_no;
    assign lane_no = (LANE_W+1)'(k);
    assign rel     = lane_no - {1'b0, start_lane};
    assign lane_en[k] = hit && (lane_no >= {1'b0, start_lane})
                            && (rel < (LANE_W+1)'(len));
    always_comb begin
      case (rel)
        (LANE_W+1)'(0): lane_val[8*k +: 8] = sb0;
        (LANE_W+1)'(1): lane_val[8*k +: 8] = sb1;
        default:        lane_val[8*k +: 8] = sb2;
      endcase
    end
  end
endmodule

// File: rtl/tsi_lane_writer.sv
module tsi_lane_writer #(
  parameter int DATA_BYTES = 8
) (
  input  logic [DATA_BYTES*8-1:0] data_i,
  input  logic [DATA_BYTES-1:0]   lane_en,
  input  logic [DATA_BYTES*8-1:0] lane_val,
  output logic [DATA_BYTES*8-1:0] data_o
);
  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_mux
    assign data_o[8*k +: 8] = lane_en[k] ? lane_val[8*k +: 8] : data_i[8*k +: 8];
  end
endmodule

// File: rtl/tstamp_inserter.sv
module tstamp_inserter
  import tsi_pkg::*;
#(
  parameter int DATA_BYTES      = 8,
  parameter int POS_W           = 11,
  parameter int TS_W            = 24,
  parameter int MAX_FRAME_BYTES = 1522
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_rst,
  input  logic [1:0]              mode_i,
  input  logic [POS_W-1:0]        pos_i,
  input  logic                    wide_i,
  input  logic [TS_W-1:0]         tstamp_i,
  input  logic [DATA_BYTES*8-1:0] s_tdata,
  input  logic [DATA_BYTES-1:0]   s_tkeep,
  input  logic                    s_tvalid,
  input  logic                    s_tlast,
  output logic                    s_tready,
  output logic [DATA_BYTES*8-1:0] m_tdata,
  output logic [DATA_BYTES-1:0]   m_tkeep,
  output logic                    m_tvalid,
  output logic                    m_tlast,
  input  logic                    m_tready
);
  localparam int DATA_W     = DATA_BYTES * 8;
  localparam int BEAT_W     = $clog2(MAX_FRAME_BYTES / DATA_BYTES + 2);
  localparam int ETYPE_LANE = ETYPE_OFS % DATA_BYTES;

  logic              rst_sync_n;
  logic              beat_acc;
  logic [BEAT_W-1:0] beat_idx;
  ts_mode_e          eff_mode;
  logic [POS_W-1:0]  eff_pos;
  logic              eff_wide;
  logic [TS_W-1:0]   eff_ts;
  logic              is_ipv4;
  logic [DATA_BYTES-1:0] lane_en;
  logic [DATA_W-1:0] lane_val;
  logic [DATA_W-1:0] stamped;
  logic [15:0]       etype_bytes;

  logic                  vld_q, vld_d;
  logic [DATA_W-1:0]     data_q, data_d;
  logic [DATA_BYTES-1:0] keep_q, keep_d;
  logic                  last_q, last_d;
  logic                  load_en;

  assign s_tready    = m_tready;
  assign beat_acc    = s_tvalid & m_tready;
  assign etype_bytes = {s_tdata[8*ETYPE_LANE +: 8], s_tdata[8*(ETYPE_LANE+1) +: 8]};

  tsi_reset_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tsi_frame_tracker #(
    .DATA_BYTES(DATA_BYTES), .POS_W(POS_W), .BEAT_W(BEAT_W), .TS_W(TS_W)
  ) i_track (
    .clk(clk), .rst_n(rst_sync_n), .sw_rst(sw_rst),
    .beat_acc(beat_acc), .beat_last(s_tlast), .etype_bytes(etype_bytes),
    .live_mode(ts_mode_e'(mode_i)), .live_pos(pos_i), .live_wide(wide_i),
    .live_ts(tstamp_i), .beat_idx(beat_idx), .eff_mode(eff_mode),
    .eff_pos(eff_pos), .eff_wide(eff_wide), .eff_ts(eff_ts), .is_ipv4(is_ipv4)
  );

  tsi_stamp_planner #(
    .DATA_BYTES(DATA_BYTES), .POS_W(POS_W), .BEAT_W(BEAT_W), .TS_W(TS_W)
  ) i_plan (
    .beat_idx(beat_idx), .mode(eff_mode), .pos(eff_pos), .wide(eff_wide),
    .is_ipv4(is_ipv4), .ts(eff_ts), .lane_en(lane_en), .lane_val(lane_val)
  );

  tsi_lane_writer #(.DATA_BYTES(DATA_BYTES)) i_write (
    .data_i(s_tdata), .lane_en(lane_en), .lane_val(lane_val), .data_o(stamped)
  );

  // output stage next state
  assign load_en = m_tready | sw_rst;
  always_comb begin
    vld_d  = sw_rst ? 1'b0 : s_tvalid;
    data_d = stamped;
    keep_d = s_tkeep;
    last_d = s_tlast;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      keep_q <= '0;
      last_q <= 1'b0;
    end else if (load_en) begin
      vld_q  <= vld_d;
      data_q <= data_d;
      keep_q <= keep_d;
      last_q <= last_d;
    end
  end

  assign m_tvalid = vld_q;
  assign m_tdata  = data_q;
  assign m_tkeep  = keep_q;
  assign m_tlast  = last_q;
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker #(
  parameter int DATA_BYTES = 8,
  parameter int POS_W      = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sw_rst,
  input logic                    s_tvalid,
  input logic                    s_tlast,
  input logic [DATA_BYTES*8-1:0] s_tdata,
  input logic                    m_tready,
  input logic                    m_tvalid,
  input logic                    m_tlast,
  input logic [DATA_BYTES-1:0]   m_tkeep,
  input logic [DATA_BYTES*8-1:0] m_tdata,
  input logic [1:0]              eff_mode,
  input logic [POS_W-1:0]        eff_pos,
  input logic                    eff_wide,
  input logic [DATA_BYTES-1:0]   lane_en
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast));

  // R3
  valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    m_tready |=> (m_tvalid == $past(s_tvalid)));

  // R12
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !m_tvalid);

  // R4
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    s_tvalid && m_tready && (eff_mode == 2'd0 || eff_mode == 2'd3) |=> m_tdata == $past(s_tdata));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    s_tvalid && m_tready && !s_tlast |=>
      eff_mode == $past(eff_mode) && eff_pos == $past(eff_pos) && eff_wide == $past(eff_wide));

  // R9
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_en) <= 3);
endmodule

bind tstamp_inserter tsi_checker #(.DATA_BYTES(DATA_BYTES), .POS_W(POS_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .sw_rst(sw_rst), .s_tvalid(s_tvalid),
  .s_tlast(s_tlast), .s_tdata(s_tdata), .m_tready(m_tready), .m_tvalid(m_tvalid),
  .m_tlast(m_tlast), .m_tkeep(m_tkeep), .m_tdata(m_tdata), .eff_mode(eff_mode),
  .eff_pos(eff_pos), .eff_wide(eff_wide), .lane_en(lane_en)
);

// File: tb/test_tstamp_inserter.sv
`timescale 1ns/1ps
module test_tstamp_inserter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, sw_rst;
  logic [1:0]  mode_i;
  logic [10:0] pos_i;
  logic        wide_i;
  logic [23:0] tstamp_i;
  logic [63:0] s_tdata, m_tdata;
  logic [7:0]  s_tkeep, m_tkeep;
  logic        s_tvalid, s_tlast, s_tready;
  logic        m_tvalid, m_tlast, m_tready;

  always #(CLK_PERIOD/2) clk = ~clk;

  tstamp_inserter i_tstamp_inserter (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .mode_i(mode_i), .pos_i(pos_i),
    .wide_i(wide_i), .tstamp_i(tstamp_i), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
    .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tvalid(m_tvalid),
    .m_tlast(m_tlast), .m_tready(m_tready)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    cmp_on = 0, bp_en = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  fb [0:2047];

  // reference model state
  bit          e_vld;
  logic [63:0] e_data;
  logic [7:0]  e_keep;
  bit          e_last;
  int          m_bidx, c_mode, c_pos, c_wide;
  logic [23:0] c_ts;
  logic [15:0] m_et;

  function automatic logic [7:0] sbyte(logic [23:0] t, int len, int o);
    if (len == 3) return (o == 0) ? t[23:16] : (o == 1) ? t[15:8] : t[7:0];
    return (o == 0) ? t[15:8] : t[7:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld = 0; m_bidx = 0;
    end else if (sw_rst) begin
      e_vld = 0; m_bidx = 0;
    end else if (m_tready) begin
      e_vld = s_tvalid;
      if (s_tvalid) begin
        if (m_bidx == 0) begin
          c_mode = int'(mode_i); c_pos = int'(pos_i); c_wide = int'(wide_i);
          c_ts = tstamp_i; m_et = 16'h0;
        end
        for (int k = 0; k < 8; k++) begin
          int n; int len; logic [7:0] b;
          n = m_bidx*8 + k;
          b = s_tdata[8*k +: 8];
          if (n == 12) m_et[15:8] = b;
          if (n == 13) m_et[7:0]  = b;
          if (c_mode == 1 && m_et == 16'h0800 && n >= 18 && n <= 20)
            b = sbyte(c_ts, 3, n - 18);
          if (c_mode == 2) begin
            len = c_wide ? 3 : 2;
            if (n >= c_pos && n < c_pos + len && n/8 == c_pos/8)
              b = sbyte(c_ts, len, n - c_pos);
          end
          e_data[8*k +: 8] = b;
        end
        e_keep = s_tkeep;
        e_last = s_tlast;
        m_bidx = s_tlast ? 0 : m_bidx + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // per-clock comparison, before the driver changes inputs
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(s_tready == m_tready, "R2", "s_tready", 64'(s_tready), 64'(m_tready));
      chk(m_tvalid == e_vld, cur_req, "m_tvalid", 64'(m_tvalid), 64'(e_vld));
      if (e_vld && m_tvalid) begin
        chk(m_tdata == e_data, cur_req, "m_tdata", m_tdata, e_data);
        chk(m_tkeep == e_keep, cur_req, "m_tkeep", 64'(m_tkeep), 64'(e_keep));
        chk(m_tlast == e_last, cur_req, "m_tlast", 64'(m_tlast), 64'(e_last));
      end
    end
  end

  task automatic step(output bit taken);
    @(negedge clk);
    taken = s_tvalid && m_tready;
    #1;
    tstamp_i = tstamp_i + 24'h010305;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  endtask

  task automatic idle(int n);
    bit tk;
    for (int i = 0; i < n; i++) step(tk);
  endtask

  task automatic build(int len, logic [15:0] et, int seed);
    for (int i = 0; i < len; i++) fb[i] = 8'(i*29 + seed*7 + 3);
    fb[12] = et[15:8];
    fb[13] = et[7:0];
  endtask

  task automatic send_frame(int len, bit gaps, int scramble_beat, int stop_after);
    int nb;
    bit tk;
    nb = (len + 7) / 8;
    for (int b = 0; b < nb; b++) begin
      int rem;
      if (gaps && lfsr[2]) begin
        s_tvalid = 0;
        step(tk);
      end
      for (int k = 0; k < 8; k++) s_tdata[8*k +: 8] = fb[b*8 + k];
      rem = len - b*8;
      s_tkeep = (rem >= 8) ? 8'hFF : 8'((1 << rem) - 1);
      s_tlast = (b == nb - 1);
      s_tvalid = 1;
      do step(tk); while (!tk);
      if (b == scramble_beat) begin
        mode_i = mode_i ^ 2'b11;
        pos_i  = pos_i ^ 11'h005;
        wide_i = ~wide_i;
      end
      if (b == stop_after) break;
    end
    s_tvalid = 0;
    s_tlast  = 0;
  endtask

  task automatic run(string req, int mode, int pos, bit wide, int len,
                     logic [15:0] et, bit bp, bit gaps, int scr);
    cur_req = req;
    bp_en = bp;
    mode_i = 2'(mode); pos_i = 11'(pos); wide_i = wide;
    build(len, et, len + pos);
    send_frame(len, gaps, scr, -1);
    bp_en = 0;
    idle(4);
  endtask

  task automatic finish_bench();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_bench();
  end

  initial begin
    rst_n = 0; sw_rst = 0; mode_i = 0; pos_i = 0; wide_i = 0; tstamp_i = 24'h123456;
    s_tdata = 0; s_tkeep = 0; s_tvalid = 0; s_tlast = 0; m_tready = 1;
    repeat (3) @(negedge clk);
    chk(m_tvalid == 1'b0, "R1", "m_tvalid in reset", 64'(m_tvalid), 64'd0);
    #1 rst_n = 1;
    idle(4);
    chk(m_tvalid == 1'b0, "R1", "m_tvalid after reset", 64'(m_tvalid), 64'd0);
    cmp_on = 1;

    run("R4", 0, 0, 0, 64, 16'h0800, 0, 0, -1);
    run("R4", 3, 0, 0, 60, 16'h0800, 0, 0, -1);
    run("R5", 1, 0, 0, 70, 16'h0800, 0, 0, -1);
    run("R3", 1, 0, 0, 70, 16'h0800, 1, 1, -1);
    run("R6", 1, 0, 0, 64, 16'h86DD, 0, 0, -1);
    run("R6", 1, 0, 0, 64, 16'h0801, 1, 0, -1);
    run("R7", 2, 5, 0, 64, 16'h0800, 0, 0, -1);
    run("R7", 2, 100, 0, 128, 16'h1234, 1, 0, -1);
    run("R8", 2, 3, 1, 64, 16'h1234, 0, 0, -1);
    run("R8", 2, 37, 1, 66, 16'h0800, 1, 1, -1);
    run("R9", 2, 6, 1, 64, 16'h1234, 0, 0, -1);
    run("R9", 2, 7, 0, 64, 16'h1234, 0, 0, -1);
    run("R9", 2, 200, 1, 64, 16'h1234, 0, 0, -1);
    run("R9", 2, 1518, 0, 1522, 16'h1234, 0, 0, -1);
    run("R10", 2, 2, 1, 40, 16'h1234, 1, 1, -1);
    run("R10", 1, 0, 0, 64, 16'h0800, 1, 1, -1);
    run("R11", 1, 0, 0, 64, 16'h0800, 0, 0, 0);
    run("R11", 2, 18, 0, 64, 16'h0800, 1, 0, 1);
    run("R11", 0, 20, 1, 64, 16'h0800, 0, 0, 0);

    // R12: abort a frame with the software reset, then send a fresh frame
    cur_req = "R12";
    mode_i = 2; pos_i = 2; wide_i = 1;
    build(64, 16'h0800, 9);
    send_frame(64, 0, -1, 2);
    sw_rst = 1;
    idle(1);
    chk(m_tvalid == 1'b0, "R12", "m_tvalid after sw_rst", 64'(m_tvalid), 64'd0);
    sw_rst = 0;
    mode_i = 2; pos_i = 10; wide_i = 0;
    build(48, 16'h0800, 11);
    send_frame(48, 0, -1, -1);
    idle(4);

    finish_bench();
  end
endmodule